// File: doc/BRIEF.md
# Sleep Mode Controller

This block is the power-management controller of a small microcontroller core. Software programs a control register with a three-bit mode field and a sleep-enable flag. When the core executes its sleep instruction it sends a one-cycle pulse. If sleep is enabled and the mode code is a defined one, the controller stops the CPU clock and any other clock domains that the mode turns off. The domains are the peripheral I/O group (serial ports, timers, comparator), the ADC and the main oscillator.

The controller stays asleep until an enabled interrupt request or a reset event arrives. It then runs a mode-dependent start-up delay with only the oscillator running. After that it holds the CPU for exactly four more cycles with every other domain clocked. Finally it raises `cpu_run` together with a wake-cause flag that tells the core whether to take the interrupt path or restart from the reset vector. The block has no output that could clear the register file or SRAM.

The sequencer has four states:
- `ST_RUN`: the CPU is executing.
- `ST_SLEEP`: the selected domains are gated.
- `ST_STARTUP`: the oscillator is settling.
- `ST_HALT`: the fixed four-cycle CPU hold.

The state transitions are:
- RUN→SLEEP on an accepted sleep pulse.
- SLEEP→STARTUP on a wake event when the mode's delay is non-zero.
- SLEEP→HALT on a wake event when the delay is zero.
- STARTUP→HALT when the delay counter expires.
- HALT→RUN after the fourth halt cycle.

Top module: `slp_ctrl`

## Requirements
- R1: The control register reads as {4'b0000, mode[2:0], sleep_en}: bit 0 is sleep-enable, bits 3..1 are the mode code, and bits 7..4 always read zero. A write with `reg_we` loads wdata[3:0]. After `rst_n` the register reads 8'h00.
- R2: A sleep pulse while sleep-enable is 0 is ignored: `cpu_run` stays 1 and all four clock enables stay 1.
- R3: While asleep, the clock enables, written as {cpu,io,adc,osc}, are 0111 for mode 000 (Idle), 0011 for mode 001 (ADC noise reduction), 0000 for mode 010 (Power-down) and 0001 for mode 110 (Standby).
- R4: A sleep pulse with a reserved mode code (011, 100, 101, 111) is a no-operation: `cpu_run` stays 1 and all clock enables stay 1.
- R5: While asleep with neither `irq_req` nor `wake_rst` asserted, the block remains asleep with `cpu_run` at 0.
- R6: The start-up delay D is 0 cycles for Idle and ADC noise reduction, SB_DLY cycles for Standby, and PD_DLY cycles for Power-down. During the start-up delay only the oscillator enable is 1.
- R7: After the start-up delay the CPU is held for exactly four cycles with the enables {cpu,io,adc,osc} = 0111. `cpu_run` is first seen high D+4 clock cycles after the edge that samples the wake event.
- R8: `wake_cause` is 0 for an interrupt wake and 1 for a reset wake, and it is valid when `cpu_run` rises. If both events arrive together, reset takes priority.
- R9: An interrupt wake leaves the control register unchanged, so sleep-enable is not cleared by hardware. A `wake_rst` pulse clears the register to 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| sleep_pulse | input | 1 | One-cycle pulse when the sleep instruction executes |
| irq_req | input | 1 | Enabled interrupt request (already masked) |
| wake_rst | input | 1 | Reset event seen during operation or sleep |
| cpu_run | output | 1 | CPU may execute |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_io | output | 1 | Peripheral I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| clk_en_osc | output | 1 | Main oscillator enable |
| wake_cause | output | 1 | 0 = interrupt wake, 1 = reset wake |

## Verification
The bench sweeps all eight mode codes against both values of sleep-enable and both wake sources. Disabled and reserved requests must leave the core running, while the four defined modes must show their distinct gating patterns. For each wake, the bench counts the cycles until `cpu_run` rises and compares the count with the mode's start-up delay plus four. This separates the zero-delay modes from Standby and Power-down. Reset wakes also assert the interrupt, which shows that reset takes priority. The register is read back after each wake to tell a cleared register from a preserved one.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_STARTUP, ST_HALT} slp_state_t;

    typedef struct packed {
        logic cpu;
        logic io;
        logic adc;
        logic osc;
    } clk_en_t;

    localparam logic [2:0] MODE_IDLE  = 3'b000;
    localparam logic [2:0] MODE_ADCNR = 3'b001;
    localparam logic [2:0] MODE_PDOWN = 3'b010;
    localparam logic [2:0] MODE_STBY  = 3'b110;
endpackage

// File: rtl/slp_ctrl_reg.sv
module slp_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    input  logic       wake_rst,
    output logic [7:0] reg_rdata,
    output logic [2:0] mode,
    output logic       sleep_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode     <= 3'b000;
            sleep_en <= 1'b0;
        end else if (wake_rst) begin
            mode     <= 3'b000;
            sleep_en <= 1'b0;
        end else if (reg_we) begin
            mode     <= reg_wdata[3:1];
            sleep_en <= reg_wdata[0];
        end
    end

    assign reg_rdata = {4'b0000, mode, sleep_en};
endmodule

// File: rtl/slp_mode_dec.sv
module slp_mode_dec
    import slp_pkg::*;
#(
    parameter int PD_DLY = 16,
    parameter int SB_DLY = 6,
    parameter int CNT_W  = 5
) (
    input  logic [2:0]       mode,
    output logic             mode_valid,
    output clk_en_t          sleep_gate,
    output logic [CNT_W-1:0] start_dly
);
    always_comb begin
        mode_valid = 1'b1;
        sleep_gate = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b0};
        start_dly  = '0;
        unique case (mode)
            MODE_IDLE: begin
                sleep_gate = '{cpu: 1'b0, io: 1'b1, adc: 1'b1, osc: 1'b1};
            end
            MODE_ADCNR: begin
                sleep_gate = '{cpu: 1'b0, io: 1'b0, adc: 1'b1, osc: 1'b1};
            end
            MODE_PDOWN: begin
                start_dly = CNT_W'(PD_DLY);
            end
            MODE_STBY: begin
                sleep_gate = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b1};
                start_dly  = CNT_W'(SB_DLY);
            end
            default: begin
                mode_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/slp_seq.sv
module slp_seq
    import slp_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_pulse,
    input  logic             sleep_en,
    input  logic             mode_valid,
    input  clk_en_t          sleep_gate,
    input  logic [CNT_W-1:0] start_dly,
    input  logic             irq_req,
    input  logic             wake_rst,
    output logic             cpu_run,
    output clk_en_t          clk_en,
    output logic             wake_cause
);
    localparam logic [CNT_W-1:0] HALT_LAST = CNT_W'(3);

    slp_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    clk_en_t          gate_q;
    logic [CNT_W-1:0] dly_q;
    logic             cause_nx;
    logic             wake_ev;

    assign wake_ev = irq_req | wake_rst;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        cause_nx = wake_cause;
        unique case (state)
            ST_RUN: begin
                if (sleep_pulse && sleep_en && mode_valid) state_nx = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (wake_ev) begin
                    cause_nx = wake_rst;
                    if (dly_q != '0) begin
                        state_nx = ST_STARTUP;
                        cnt_nx   = dly_q - CNT_W'(1);
                    end else begin
                        state_nx = ST_HALT;
                        cnt_nx   = HALT_LAST;
                    end
                end
            end
            ST_STARTUP: begin
                if (wake_rst) cause_nx = 1'b1;
                if (cnt == '0) begin
                    state_nx = ST_HALT;
                    cnt_nx   = HALT_LAST;
                end else begin
                    cnt_nx = cnt - CNT_W'(1);
                end
            end
            ST_HALT: begin
                if (wake_rst) cause_nx = 1'b1;
                if (cnt == '0) state_nx = ST_RUN;
                else           cnt_nx = cnt - CNT_W'(1);
            end
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_RUN;
            cnt        <= '0;
            wake_cause <= 1'b0;
            gate_q     <= '{cpu: 1'b1, io: 1'b1, adc: 1'b1, osc: 1'b1};
            dly_q      <= '0;
        end else begin
            state      <= state_nx;
            cnt        <= cnt_nx;
            wake_cause <= cause_nx;
            if (state == ST_RUN && state_nx == ST_SLEEP) begin
                gate_q <= sleep_gate;
                dly_q  <= start_dly;
            end
        end
    end

    always_comb begin
        cpu_run = 1'b0;
        clk_en  = '{cpu: 1'b1, io: 1'b1, adc: 1'b1, osc: 1'b1};
        unique case (state)
            ST_RUN:     cpu_run = 1'b1;
            ST_SLEEP:   clk_en = gate_q;
            ST_STARTUP: clk_en = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b1};
            ST_HALT:    clk_en = '{cpu: 1'b0, io: 1'b1, adc: 1'b1, osc: 1'b1};
            default:    cpu_run = 1'b1;
        endcase
    end

    AST_SE_LOW_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_pulse && !sleep_en) |=> (state == ST_RUN)); // R2
    AST_RSVD_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_pulse && !mode_valid) |=> (state == ST_RUN)); // R4
    AST_HOLD_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !irq_req && !wake_rst) |=> (state == ST_SLEEP)); // R5
    AST_HALT_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_run) |-> ($past(state == ST_HALT, 1) && $past(state == ST_HALT, 4)
                            && !$past(state == ST_HALT, 5))); // R7
    AST_CAUSE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && wake_rst) |=> wake_cause); // R8
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
    import slp_pkg::*;
#(
    parameter int PD_DLY = 16,
    parameter int SB_DLY = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sleep_pulse,
    input  logic       irq_req,
    input  logic       wake_rst,
    output logic       cpu_run,
    output logic       clk_en_cpu,
    output logic       clk_en_io,
    output logic       clk_en_adc,
    output logic       clk_en_osc,
    output logic       wake_cause
);
    localparam int MAX_DLY = (PD_DLY > SB_DLY) ? ((PD_DLY > 4) ? PD_DLY : 4)
                                               : ((SB_DLY > 4) ? SB_DLY : 4);
    localparam int CNT_W   = $clog2(MAX_DLY + 1);

    logic [2:0]       mode;
    logic             sleep_en;
    logic             mode_valid;
    clk_en_t          sleep_gate;
    logic [CNT_W-1:0] start_dly;
    clk_en_t          clk_en;

    slp_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .wake_rst  (wake_rst),
        .reg_rdata (reg_rdata),
        .mode      (mode),
        .sleep_en  (sleep_en)
    );

    slp_mode_dec #(.PD_DLY(PD_DLY), .SB_DLY(SB_DLY), .CNT_W(CNT_W)) u_dec (
        .mode       (mode),
        .mode_valid (mode_valid),
        .sleep_gate (sleep_gate),
        .start_dly  (start_dly)
    );

    slp_seq #(.CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_pulse (sleep_pulse),
        .sleep_en    (sleep_en),
        .mode_valid  (mode_valid),
        .sleep_gate  (sleep_gate),
        .start_dly   (start_dly),
        .irq_req     (irq_req),
        .wake_rst    (wake_rst),
        .cpu_run     (cpu_run),
        .clk_en      (clk_en),
        .wake_cause  (wake_cause)
    );

    assign clk_en_cpu = clk_en.cpu;
    assign clk_en_io  = clk_en.io;
    assign clk_en_adc = clk_en.adc;
    assign clk_en_osc = clk_en.osc;

    AST_CPU_CLK_OFF_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_run |-> !clk_en_cpu); // R3
    AST_REG_KEPT_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_run && !wake_rst && !reg_we) |=> $stable(reg_rdata)); // R9
endmodule

// File: tb/sim_slp_ctrl.sv
module sim_slp_ctrl;
    localparam int PD = 9;
    localparam int SB = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sleep_pulse = 1'b0;
    logic       irq_req = 1'b0;
    logic       wake_rst = 1'b0;
    logic       cpu_run, clk_en_cpu, clk_en_io, clk_en_adc, clk_en_osc, wake_cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    slp_ctrl #(.PD_DLY(PD), .SB_DLY(SB)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sleep_pulse(sleep_pulse), .irq_req(irq_req),
        .wake_rst(wake_rst), .cpu_run(cpu_run), .clk_en_cpu(clk_en_cpu),
        .clk_en_io(clk_en_io), .clk_en_adc(clk_en_adc), .clk_en_osc(clk_en_osc),
        .wake_cause(wake_cause)
    );

    function automatic logic [3:0] en_vec();
        return {clk_en_cpu, clk_en_io, clk_en_adc, clk_en_osc};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit mode_ok(input logic [2:0] m);
        return (m == 3'b000) || (m == 3'b001) || (m == 3'b010) || (m == 3'b110);
    endfunction

    function automatic logic [3:0] exp_gate(input logic [2:0] m);
        case (m)
            3'b000:  return 4'b0111;
            3'b001:  return 4'b0011;
            3'b110:  return 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic int exp_dly(input logic [2:0] m);
        if (m == 3'b010) return PD;
        if (m == 3'b110) return SB;
        return 0;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(reg_rdata == 8'h00, "R1 reset value", reg_rdata, 0);
        chk(cpu_run == 1'b1, "R1 reset run", cpu_run, 1);
        chk(en_vec() == 4'hF, "R1 reset enables", en_vec(), 15);

        for (int code = 0; code < 8; code++) begin
            for (int se = 0; se < 2; se++) begin
                for (int wk = 0; wk < 2; wk++) begin
                    logic [2:0] m;
                    logic [7:0] exp_rd;
                    int n;
                    int d;
                    m = 3'(code);
                    exp_rd = {4'b0000, m, 1'(se)};
                    reg_we = 1'b1;
                    reg_wdata = {4'hA, m, 1'(se)};
                    @(negedge clk);
                    reg_we = 1'b0;
                    chk(reg_rdata == exp_rd, "R1 readback", reg_rdata, exp_rd);

                    sleep_pulse = 1'b1;
                    @(negedge clk);
                    sleep_pulse = 1'b0;
                    if (!(se == 1 && mode_ok(m))) begin
                        if (se == 0) begin
                            chk(cpu_run == 1'b1, "R2 run kept", cpu_run, 1);
                            chk(en_vec() == 4'hF, "R2 enables kept", en_vec(), 15);
                        end else begin
                            chk(cpu_run == 1'b1, "R4 reserved run kept", cpu_run, 1);
                            chk(en_vec() == 4'hF, "R4 reserved enables", en_vec(), 15);
                        end
                        @(negedge clk);
                        chk(cpu_run == 1'b1, "R2 R4 still running", cpu_run, 1);
                        continue;
                    end
                    chk(en_vec() == exp_gate(m), "R3 sleep gating", en_vec(), exp_gate(m));
                    repeat (2) @(negedge clk);
                    chk(cpu_run == 1'b0, "R5 stays asleep", cpu_run, 0);
                    chk(en_vec() == exp_gate(m), "R5 gating held", en_vec(), exp_gate(m));

                    irq_req = 1'b1;
                    wake_rst = (wk == 1);
                    @(negedge clk);
                    irq_req = 1'b0;
                    wake_rst = 1'b0;
                    d = exp_dly(m);
                    if (d > 0)
                        chk(en_vec() == 4'b0001, "R6 startup enables", en_vec(), 1);
                    else
                        chk(en_vec() == 4'b0111, "R7 halt enables", en_vec(), 7);
                    n = 0;
                    while (!cpu_run && n < 100) begin
                        @(negedge clk);
                        n++;
                        if (!cpu_run && n == d)
                            chk(en_vec() == 4'b0111, "R7 halt enables", en_vec(), 7);
                    end
                    chk(n == d + 4, "R6 R7 wake latency", n, d + 4);
                    chk(wake_cause == 1'(wk), "R8 wake cause", wake_cause, wk);
                    if (wk == 1)
                        chk(reg_rdata == 8'h00, "R9 cleared by reset", reg_rdata, 0);
                    else
                        chk(reg_rdata == exp_rd, "R9 kept on irq", reg_rdata, exp_rd);
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule